// File: doc/BRIEF.md
# Pipelined Cascaded Wide Signed Multiplier

The block forms the full-width two's-complement product of two wide signed operands, 35 bits each by default, and returns a 70-bit result. Each operand is split at bit 17. The lower 17 bits form an unsigned field, which is zero-extended to 18 bits. The upper 18 bits form a signed field. Four 18x18 signed multiply slices then produce the partial products, which are summed on a chain of registered adders.

The chain runs in a fixed order: low×low, then low×high, then high×low, then high×high. Each stage places its partial product at the weight of that slice (0, 17, 17 and 34 bits) and adds it to the sum passed down from the stage before. Registers sit at three kinds of place: two levels on the operands, one after every multiply, and one after every adder. No cycle therefore holds more than one multiply or one add.

A configurable delay line on the result sets the total latency. A valid flag travels with the data through a shift register of the same length. With valid input on every cycle, the block returns one product per cycle.

Top module: `wide_smul_cascade`

## Requirements
- R1: `product_o` equals the exact signed product of `a_i` and `b_i`, both read as 35-bit two's-complement values, given as a 70-bit two's-complement result.
- R2: The result and its valid flag appear after the LAT-th rising edge, counting the edge that samples the inputs as the first, where LAT = 7 + OUT_DLY (8 by default). They are not present one cycle earlier.
- R3: A different operand pair may be applied on every cycle, and each pair's product emerges LAT edges later, in order and unaffected by its neighbours.
- R4: `valid_o` repeats `valid_i` delayed by LAT edges. A cycle applied with `valid_i` low yields `valid_o` low in the matching output cycle.
- R5: While `rst_ni` is low, `valid_o` and `product_o` are 0, effective at once without a clock edge. After release they stay 0 until the first sampled pair reaches the output LAT edges later.
- R6: The most negative operand times itself (-2^34 × -2^34) gives +2^68.
- R7: The most negative operand times the most positive operand gives -(2^68 - 2^34).
- R8: A zero operand gives 0. An operand of +1 returns the other operand sign-extended. An operand of -1 returns its negation.
- R9: The data path is not gated by `valid_i`. Operands sampled with `valid_i` low still produce their product at the output LAT edges later.
- R10: Operands whose low 17 bits are all ones, or whose value sits exactly at ±2^17, give exact products, because carries across the bit-17 split are weighted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks the current operand pair as valid |
| a_i | input | 35 | Multiplicand, two's complement |
| b_i | input | 35 | Multiplier, two's complement |
| valid_o | output | 1 | Marks `product_o` as a valid result |
| product_o | output | 70 | Signed product, two's complement |

## Verification
The two functions that share a cycle are the acceptance of a fresh operand pair and the delivery of an earlier pair's product. They overlap whenever operands stream back to back. This overlap is provoked by driving a 16-entry vector table on consecutive cycles, with no idle cycles, while also toggling `valid_i`. On each cycle the product and flag leaving the block are compared against the entry applied LAT cycles earlier. A mid-stream reset also lands while results are leaving. It is judged by requiring the outputs to clear at once and then to stay at 0 until exactly LAT edges after release.

// File: rtl/mulc_pkg.sv
package mulc_pkg;

  typedef enum logic [1:0] {
    SL_LL = 2'd0,
    SL_LH = 2'd1,
    SL_HL = 2'd2,
    SL_HH = 2'd3
  } slice_e;

  function automatic bit a_is_hi(slice_e k);
    return (k == SL_HL) || (k == SL_HH);
  endfunction

  function automatic bit b_is_hi(slice_e k);
    return (k == SL_LH) || (k == SL_HH);
  endfunction

  // weight of a slice inside the full product
  function automatic int slice_shift(slice_e k, int lo_w);
    return (a_is_hi(k) ? lo_w : 0) + (b_is_hi(k) ? lo_w : 0);
  endfunction

endpackage

// File: rtl/mulc_delay.sv
module mulc_delay #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) pipe_q[k] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < N; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[N-1];

endmodule

// File: rtl/mulc_slice.sv
module mulc_slice
  import mulc_pkg::*;
#(
  parameter int     SW   = 18,
  parameter int     DLY  = 0,
  parameter slice_e KIND = SL_LL,
  localparam int    PRW  = 2 * SW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [SW-1:0]  op_a_i,
  input  logic signed [SW-1:0]  op_b_i,
  output logic signed [PRW-1:0] prod_o
);

  logic signed [SW-1:0] op_a_d, op_b_d;

  // align this slice with the running sum of the same operand pair
  generate
    if (DLY == 0) begin : g_nodly
      assign op_a_d = op_a_i;
      assign op_b_d = op_b_i;
    end else begin : g_dly
      logic [2*SW-1:0] ab_d;
      mulc_delay #(.W(2 * SW), .N(DLY)) u_align (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({op_a_i, op_b_i}),
        .q_o   (ab_d)
      );
      assign op_a_d = ab_d[2*SW-1:SW];
      assign op_b_d = ab_d[SW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= op_a_d * op_b_d;
  end

  generate
    if (!a_is_hi(KIND) && !b_is_hi(KIND)) begin : g_chk_ll
      // R10
      ll_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !prod_o[PRW-1]);
    end else if (a_is_hi(KIND) && b_is_hi(KIND)) begin : g_chk_hh
      // R6
      hh_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prod_o <= (PRW'(1) <<< (PRW - 2)));
    end else begin : g_chk_mix
      // R10
      mix_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prod_o[PRW-1] == prod_o[PRW-2]);
    end
  endgenerate

endmodule

// File: rtl/mulc_acc.sv
module mulc_acc #(
  parameter int PW    = 70,
  parameter int PRW   = 36,
  parameter int SHIFT = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [PW-1:0]  sum_i,
  input  logic signed [PRW-1:0] prod_i,
  output logic signed [PW-1:0]  sum_o
);

  logic signed [PW-1:0] term;

  always_comb term = PW'(prod_i) <<< SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= sum_i + term;
  end

endmodule

// File: rtl/wide_smul_cascade.sv
module wide_smul_cascade
  import mulc_pkg::*;
#(
  parameter int W       = 35,
  parameter int LO_W    = 17,
  parameter int OUT_DLY = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic            valid_o,
  output logic [2*W-1:0]  product_o
);

  localparam int HI_W   = W - LO_W;
  localparam int SW     = (LO_W + 1 > HI_W) ? LO_W + 1 : HI_W;
  localparam int PRW    = 2 * SW;
  localparam int PW     = 2 * W;
  localparam int IN_DLY = 2;
  localparam int NSL    = 4;
  localparam int LAT    = IN_DLY + 1 + NSL + OUT_DLY;

  logic [2*W-1:0] ab_q;
  logic [W-1:0]   a_q, b_q;

  mulc_delay #(.W(2 * W), .N(IN_DLY)) u_in (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({a_i, b_i}),
    .q_o   (ab_q)
  );
  assign a_q = ab_q[2*W-1:W];
  assign b_q = ab_q[W-1:0];

  // low field zero-extended, high field sign-extended
  logic signed [SW-1:0] a_lo, a_hi, b_lo, b_hi;
  always_comb begin
    a_lo = SW'(a_q[LO_W-1:0]);
    b_lo = SW'(b_q[LO_W-1:0]);
    a_hi = SW'($signed(a_q[W-1:LO_W]));
    b_hi = SW'($signed(b_q[W-1:LO_W]));
  end

  logic signed [PW-1:0] sum [NSL+1];
  assign sum[0] = '0;

  for (genvar k = 0; k < NSL; k++) begin : g_stage
    localparam slice_e KIND = slice_e'(k);
    logic signed [PRW-1:0] prod;

    mulc_slice #(.SW(SW), .DLY(k), .KIND(KIND)) u_slice (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .op_a_i(a_is_hi(KIND) ? a_hi : a_lo),
      .op_b_i(b_is_hi(KIND) ? b_hi : b_lo),
      .prod_o(prod)
    );

    mulc_acc #(.PW(PW), .PRW(PRW), .SHIFT(slice_shift(KIND, LO_W))) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sum_i (sum[k]),
      .prod_i(prod),
      .sum_o (sum[k+1])
    );
  end

  generate
    if (OUT_DLY == 0) begin : g_out_direct
      assign product_o = sum[NSL];
    end else begin : g_out_dly
      mulc_delay #(.W(PW), .N(OUT_DLY)) u_out (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (sum[NSL]),
        .q_o   (product_o)
      );
    end
  endgenerate

  mulc_delay #(.W(1), .N(LAT)) u_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (valid_i),
    .q_o   (valid_o)
  );

  // ---- checks ----
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);
  localparam logic signed [PW-1:0] P_MAX = PW'(1) <<< (PW - 2);
  localparam logic signed [PW-1:0] P_MIN =
    -((PW'(1) <<< (W - 1)) * ((PW'(1) <<< (W - 1)) - PW'(1)));

  logic [CW-1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst <= '0;
    else if (since_rst != LAT_C) since_rst <= since_rst + 1'b1;
  end

  // R5
  fill_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < LAT_C) |-> (!valid_o && product_o == '0));

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(product_o) <= P_MAX) && ($signed(product_o) >= P_MIN));

endmodule

// File: tb/tb_wide_smul_cascade.sv
module tb_wide_smul_cascade;

  localparam int W       = 35;
  localparam int PW      = 2 * W;
  localparam int OUT_DLY = 1;
  localparam int LAT     = 7 + OUT_DLY;
  localparam int NV      = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  a_i = '0, b_i = '0;
  logic          valid_o;
  logic [PW-1:0] product_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  wide_smul_cascade #(.W(W), .LO_W(17), .OUT_DLY(OUT_DLY)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .valid_o  (valid_o),
    .product_o(product_o)
  );

  // {valid, a, b}
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b1, 35'h1_2345_6789, 35'h6_DCBA_9876},
    {1'b1, 35'h5_5555_5555, 35'h2_AAAA_AAAA},
    {1'b0, 35'h0_0000_0007, 35'h0_0000_0009},
    {1'b1, 35'h4_0000_0000, 35'h4_0000_0000},
    {1'b1, 35'h4_0000_0000, 35'h3_FFFF_FFFF},
    {1'b1, 35'h0_0000_0000, 35'h7_1234_5678},
    {1'b1, 35'h7_FFFF_FFFF, 35'h7_FFFF_FFFF},
    {1'b1, 35'h0_0000_0001, 35'h5_0F0F_0F0F},
    {1'b0, 35'h3_FFFF_FFFF, 35'h7_FFFF_FFFF},
    {1'b1, 35'h0_0001_FFFF, 35'h0_0001_FFFF},
    {1'b1, 35'h7_FFFE_0000, 35'h0_0002_0000},
    {1'b1, 35'h2_4681_3579, 35'h0_0000_0000},
    {1'b1, 35'h3_0001_FFFF, 35'h4_FFFE_0001},
    {1'b1, 35'h7_FFFF_FFFF, 35'h0_0000_0001},
    {1'b1, 35'h6_0000_0000, 35'h1_FFFF_FFFF},
    {1'b1, 35'h0_ABCD_EF01, 35'h7_FFFE_FFFF}
  };

  function automatic logic [PW-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [PW-1:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic shot(logic [W-1:0] a, logic [W-1:0] b, logic [PW-1:0] exp, string tag);
    @(negedge clk);
    valid_i = 1'b1; a_i = a; b_i = b;
    @(negedge clk);
    valid_i = 1'b0; a_i = '0; b_i = '0;
    for (int m = 2; m <= LAT; m++) begin
      @(negedge clk);
      if (m == LAT - 1) chk("R2 valid early", PW'(valid_o), '0);
      if (m == LAT) begin
        chk("R2 valid on time", PW'(valid_o), PW'(1));
        chk(tag, product_o, exp);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R5 reset state
    repeat (3) @(negedge clk);
    chk("R5 reset valid", PW'(valid_o), '0);
    chk("R5 reset product", product_o, '0);
    rst_ni = 1'b1;

    // streamed table, R1 R3 R4 R9
    for (int m = 0; m < NV + LAT; m++) begin
      @(negedge clk);
      if (m >= LAT) begin
        logic [2*W:0] v;
        v = VEC[m-LAT];
        chk("R4 valid follows", PW'(valid_o), PW'(v[2*W]));
        if (v[2*W]) chk("R1 R3 product", product_o, ref_mul(v[2*W-1:W], v[W-1:0]));
        else        chk("R9 ungated product", product_o, ref_mul(v[2*W-1:W], v[W-1:0]));
      end
      if (m < NV) begin
        valid_i = VEC[m][2*W]; a_i = VEC[m][2*W-1:W]; b_i = VEC[m][W-1:0];
      end else begin
        valid_i = 1'b0; a_i = '0; b_i = '0;
      end
    end

    // directed corners
    shot(35'h4_0000_0000, 35'h4_0000_0000, PW'(1) << 68, "R6 min squared");
    shot(35'h4_0000_0000, 35'h3_FFFF_FFFF, -(PW'(1) << 68) + (PW'(1) << 34), "R7 min times max");
    shot(35'h3_FFFF_FFFF, 35'h4_0000_0000, -(PW'(1) << 68) + (PW'(1) << 34), "R7 max times min");
    shot(35'h0_0000_0000, 35'h4_0000_0000, '0, "R8 zero");
    shot(35'h7_FFFF_FFFF, 35'h3_FFFF_FFFF, -(PW'(1) << 34) + PW'(1), "R8 minus one");
    shot(35'h4_0000_0000, 35'h0_0000_0001, -(PW'(1) << 34), "R8 plus one");
    shot(35'h0_0001_FFFF, 35'h0_0001_FFFF, (PW'(1) << 34) - (PW'(1) << 18) + PW'(1), "R10 low ones");
    shot(35'h7_FFFE_0000, 35'h0_0001_FFFF, -(PW'(1) << 34) + (PW'(1) << 17), "R10 split edge");

    // mid-stream reset, R5 and R2 after release
    @(negedge clk);
    valid_i = 1'b1; a_i = 35'd3; b_i = 35'd5;
    repeat (LAT) @(negedge clk);
    chk("R3 stream valid", PW'(valid_o), PW'(1));
    rst_ni = 1'b0;
    #1;
    chk("R5 async clear valid", PW'(valid_o), '0);
    chk("R5 async clear product", product_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int m = 1; m <= LAT; m++) begin
      @(negedge clk);
      if (m < LAT) begin
        chk("R5 fill valid", PW'(valid_o), '0);
        chk("R5 fill product", product_o, '0);
      end else begin
        chk("R2 first valid", PW'(valid_o), PW'(1));
        chk("R2 first product", product_o, PW'(15));
      end
    end
    valid_i = 1'b0;

    summary();
    $finish;
  end

endmodule